// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a packed single-precision floating-point word into a 32-bit integer, either unsigned or two's-complement signed. A 2-bit field selects one of four rounding directions. A force-truncate input overrides that field with round-toward-zero for the current item. Three flags come out beside the integer: invalid, inexact and input-denormal. The block does not read registers and does not update any flag state.

Each item carries the operand, the signed/unsigned choice, the rounding field and the truncate bit. An item enters on a valid/ready handshake and appears one cycle later in an output register, together with its flags. The upstream side sees ready high whenever that register is empty, or whenever the downstream side takes the current result in the same cycle. While the output is valid and `out_ready` is low, the result and flags stay frozen and no new item is taken. The result is therefore lost only if the consumer never takes it.

Top module: `f2i_conv`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: An item is taken when `in_valid` and `in_ready` are both high, and its result is valid in the next cycle. `in_ready` is high when the output is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_int` and the three flags hold their values. Results leave in the order the items came in.
- R3: For biased exponents from 126 to 158, the output is the magnitude rounded to an integer under `in_rmode`. The encodings are 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. A signed result is negated when the input is negative.
- R4: In the R3 range, inexact is set when discarded fraction bits are nonzero, unless that item also raises invalid.
- R5: Unsigned output with a biased exponent of 159 or more (this includes infinities and NaNs) gives 0 for a negative sign and 0xFFFFFFFF otherwise, with invalid set.
- R6: Signed output with a NaN input gives 0 with invalid. Any other input with a biased exponent of 159 or more gives 0x80000000 when negative and 0x7FFFFFFF otherwise, with invalid set.
- R7: Signed output in the R3 range clamps with invalid when the rounded magnitude is above 0x7FFFFFFF (positive) or above 0x80000000 (negative). The clamp value is that limit.
- R8: Unsigned output from a negative input whose rounded magnitude is nonzero gives 0 with invalid. Every negative input gives 0 in unsigned mode.
- R9: A nonzero input with a biased exponent below 126 sets inexact. It gives 1 when rounding toward +infinity with a positive sign. When rounding toward -infinity with a negative sign, it gives 0xFFFFFFFF for signed output, or 0 with invalid for unsigned. In every other case it gives 0. A zero input gives 0 with no flags.
- R10: A denormal input (exponent 0, fraction nonzero) sets the input-denormal flag, in addition to the flags of R9.
- R11: With `in_trunc` high, the item is converted as if `in_rmode` were 3, whatever the field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an item this cycle |
| in_value | input | 32 | Packed single-precision operand |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| in_rmode | input | 2 | Rounding direction (encoding in R3) |
| in_trunc | input | 1 | Force round-toward-zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The bench builds the block with its default widths: an 8-bit exponent, a 23-bit fraction and a 32-bit integer. With these widths the exponent boundaries at 126, 158 and 159 can all be reached with exact constants. Directed operands sit on those edges, on exact ties, and on the signed limits ±2^31. The bench drives each of them in both signed modes, in all four rounding directions and with truncate forced. Exponent-biased pseudo-random operands then run while `out_ready` stalls at irregular times, which exercises the hold and ordering rules.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int INT_W    = 32;
  localparam int EXP_BIAS = 127;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_POS     = 2'd1,
    RM_NEG     = 2'd2,
    RM_ZERO    = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
    logic denorm;
  } cvt_flags_t;

  // operand classification shared between stages
  typedef struct packed {
    logic neg;     // sign bit
    logic nan;     // all-ones exponent with nonzero fraction
    logic big;     // exponent at or beyond the integer range limit
    logic mid;     // magnitude of one half up to the integer range
    logic tiny;    // nonzero and below one half
    logic denorm;  // zero exponent, nonzero fraction
  } fp_class_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EW   = EXP_W,
  parameter int MW   = MAN_W,
  parameter int IW   = INT_W,
  parameter int BIAS = EXP_BIAS
) (
  input  logic [EW+MW:0]           value,
  output fp_class_t                cls,
  output logic [MW-1:0]            frac,
  output logic [$clog2(IW+1)-1:0]  shift
);
  localparam int SH_W     = $clog2(IW + 1);
  localparam int EXP_SAT  = BIAS + IW;      // first exponent past the range
  localparam int EXP_TOP  = BIAS + IW - 1;  // exponent with no fraction bits left
  localparam int EXP_HALF = BIAS - 1;       // exponent of one half

  logic [EW-1:0] expo;

  always_comb begin
    expo       = value[EW+MW-1:MW];
    frac       = value[MW-1:0];
    cls.neg    = value[EW+MW];
    cls.nan    = (&expo) && (|frac);
    cls.big    = expo >= EW'(EXP_SAT);
    cls.mid    = !cls.big && (expo >= EW'(EXP_HALF));
    cls.tiny   = (expo < EW'(EXP_HALF)) && ((|expo) || (|frac));
    cls.denorm = (expo == '0) && (|frac);
    shift      = cls.mid ? SH_W'(EXP_TOP - int'(expo)) : '0;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int MW = f2i_pkg::MAN_W,
  parameter int IW = f2i_pkg::INT_W
) (
  input  logic [MW-1:0]            frac,
  input  logic [$clog2(IW+1)-1:0]  shift,
  output logic [IW-1:0]            int_part,
  output logic [IW-1:0]            rem
);
  localparam int PAD = IW - 1 - MW;

  logic [IW-1:0]   sig;
  logic [2*IW-1:0] wide;

  // significand with hidden one at the top; one wide shift yields the
  // integer part in the upper half and a left-aligned remainder below it
  always_comb begin
    sig      = {1'b1, frac, {PAD{1'b0}}};
    wide     = {sig, {IW{1'b0}}} >> shift;
    int_part = wide[2*IW-1:IW];
    rem      = wide[IW-1:0];
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int IW = INT_W
) (
  input  logic [IW-1:0] int_part,
  input  logic [IW-1:0] rem,
  input  rnd_mode_e     mode,
  input  logic          neg,
  output logic [IW:0]   mag,
  output logic          rem_nz
);
  logic [IW-1:0] incr;
  logic          carry;

  always_comb begin
    unique case (mode)
      RM_NEAREST: incr = {int_part[0], {(IW-1){~int_part[0]}}};
      RM_POS:     incr = neg ? '0 : '1;
      RM_NEG:     incr = neg ? '1 : '0;
      default:    incr = '0;
    endcase
    // rem + incr overflows exactly when rem exceeds the complement of incr
    carry  = rem > ~incr;
    mag    = {1'b0, int_part} + {{IW{1'b0}}, carry};
    rem_nz = |rem;
  end
endmodule

// File: rtl/f2i_select.sv
module f2i_select
  import f2i_pkg::*;
#(
  parameter int IW = INT_W
) (
  input  fp_class_t     cls,
  input  logic [IW:0]   mag,
  input  logic          rem_nz,
  input  rnd_mode_e     mode,
  input  logic          is_signed,
  output logic [IW-1:0] result,
  output cvt_flags_t    flags
);
  localparam logic [IW-1:0] SMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};

  logic [IW:0] lim;

  always_comb begin
    result        = '0;
    flags.invalid = 1'b0;
    flags.inexact = 1'b0;
    flags.denorm  = cls.denorm;
    lim           = cls.neg ? {1'b0, SMIN} : {1'b0, SMAX};
    if (!is_signed && cls.big) begin
      result        = cls.neg ? '0 : '1;
      flags.invalid = 1'b1;
    end else if (is_signed && cls.nan) begin
      flags.invalid = 1'b1;
    end else if (is_signed && cls.big) begin
      result        = cls.neg ? SMIN : SMAX;
      flags.invalid = 1'b1;
    end else if (cls.mid) begin
      if (is_signed) begin
        if (mag > lim) begin
          result        = lim[IW-1:0];
          flags.invalid = 1'b1;
        end else begin
          result        = cls.neg ? -mag[IW-1:0] : mag[IW-1:0];
          flags.inexact = rem_nz;
        end
      end else if (cls.neg && (mag != '0)) begin
        flags.invalid = 1'b1;
      end else if (mag[IW]) begin
        result        = '1;
        flags.invalid = 1'b1;
      end else begin
        result        = mag[IW-1:0];
        flags.inexact = rem_nz;
      end
    end else if (cls.tiny) begin
      flags.inexact = 1'b1;
      if (mode == RM_POS && !cls.neg) begin
        result = IW'(1);
      end else if (mode == RM_NEG && cls.neg) begin
        if (is_signed) result = '1;
        else flags.invalid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EW   = EXP_W,
  parameter int MW   = MAN_W,
  parameter int IW   = INT_W,
  parameter int BIAS = EXP_BIAS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EW+MW:0]   in_value,
  input  logic             in_signed,
  input  logic [1:0]       in_rmode,
  input  logic             in_trunc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IW-1:0]    out_int,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_denorm
);
  localparam int SH_W    = $clog2(IW + 1);
  localparam int EXP_SAT = BIAS + IW;

  fp_class_t         cls;
  logic [MW-1:0]     frac;
  logic [SH_W-1:0]   shift;
  logic [IW-1:0]     int_part, rem, res_c;
  logic [IW:0]       mag;
  logic              rem_nz, fire;
  rnd_mode_e         mode_eff;
  cvt_flags_t        flags_c, flags_q;
  logic [IW-1:0]     res_q;
  logic              vld_q;

  assign mode_eff = in_trunc ? RM_ZERO : rnd_mode_e'(in_rmode);

  f2i_classify #(.EW(EW), .MW(MW), .IW(IW), .BIAS(BIAS)) u_classify (
    .value(in_value), .cls(cls), .frac(frac), .shift(shift));

  f2i_align #(.MW(MW), .IW(IW)) u_align (
    .frac(frac), .shift(shift), .int_part(int_part), .rem(rem));

  f2i_round #(.IW(IW)) u_round (
    .int_part(int_part), .rem(rem), .mode(mode_eff), .neg(cls.neg),
    .mag(mag), .rem_nz(rem_nz));

  f2i_select #(.IW(IW)) u_select (
    .cls(cls), .mag(mag), .rem_nz(rem_nz), .mode(mode_eff),
    .is_signed(in_signed), .result(res_c), .flags(flags_c));

  // single output register; a taken result frees the slot in the same cycle
  assign in_ready = !vld_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (fire) begin
        res_q   <= res_c;
        flags_q <= flags_c;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_int     = res_q;
  assign out_invalid = flags_q.invalid;
  assign out_inexact = flags_q.inexact;
  assign out_denorm  = flags_q.denorm;

  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r2_take_shows_next: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_int)
      && $stable(out_invalid) && $stable(out_inexact) && $stable(out_denorm));

  a_r5_unsigned_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_signed && (in_value[EW+MW-1:MW] >= EW'(EXP_SAT))
      |=> out_invalid && (out_int == '0 || out_int == '1));

  a_r6_signed_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_signed && (&in_value[EW+MW-1:MW]) && (|in_value[MW-1:0])
      |=> out_invalid && out_int == '0);

  a_r8_unsigned_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_signed && in_value[EW+MW] |=> out_int == '0);

  a_r10_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_value[EW+MW-1:MW] == '0) && (|in_value[MW-1:0]) |=> out_denorm);
endmodule

// File: tb/f2i_conv_bench.sv
module f2i_conv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_signed, in_trunc;
  logic [31:0] in_value;
  logic [1:0]  in_rmode;
  logic        out_valid, out_ready;
  logic [31:0] out_int;
  logic        out_invalid, out_inexact, out_denorm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [34:0] q_exp[$];
  logic [31:0] q_in[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  f2i_conv u_f2i_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_signed(in_signed), .in_rmode(in_rmode),
    .in_trunc(in_trunc), .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact),
    .out_denorm(out_denorm));

  // reference: {int, invalid, inexact, denorm}, built from the requirements
  function automatic logic [34:0] model(input logic [31:0] x, input logic sgn,
                                        input logic [1:0] rm_in, input logic tr);
    logic        neg = x[31];
    int          e   = int'(x[30:23]);
    logic [22:0] f   = x[22:0];
    logic [1:0]  rm  = tr ? 2'd3 : rm_in;
    logic [31:0] res = '0;
    logic inv = 0, inx = 0, den = (e == 0) && (f != 0);
    logic [63:0] m, ip, low, half, lim;
    logic up;
    if (!sgn && e >= 159) begin
      res = neg ? 32'h0 : 32'hFFFF_FFFF; inv = 1;
    end else if (sgn && e == 255 && f != 0) begin
      inv = 1;
    end else if (sgn && e >= 159) begin
      res = neg ? 32'h8000_0000 : 32'h7FFF_FFFF; inv = 1;
    end else if (e >= 126) begin
      m = {40'd0, 1'b1, f};
      if (e >= 150) begin
        ip = m << (e - 150); low = 0; half = 1;
      end else begin
        ip = m >> (150 - e);
        low = m & ((64'd1 << (150 - e)) - 1);
        half = 64'd1 << (149 - e);
      end
      case (rm)
        2'd0: up = (low > half) || (low == half && ip[0]);
        2'd1: up = (low != 0) && !neg;
        2'd2: up = (low != 0) && neg;
        default: up = 0;
      endcase
      ip = ip + {63'd0, up};
      if (sgn) begin
        lim = neg ? 64'h8000_0000 : 64'h7FFF_FFFF;
        if (ip > lim) begin res = lim[31:0]; inv = 1; end
        else res = neg ? -ip[31:0] : ip[31:0];
      end else begin
        if (neg && ip != 0) inv = 1;
        else if (ip > 64'hFFFF_FFFF) begin res = '1; inv = 1; end
        else res = ip[31:0];
      end
      inx = (low != 0) && !inv;
    end else if (e != 0 || f != 0) begin
      inx = 1;
      if (rm == 2'd1 && !neg) res = 32'd1;
      else if (rm == 2'd2 && neg) begin
        if (sgn) res = 32'hFFFF_FFFF; else inv = 1;
      end
    end
    return {res, inv, inx, den};
  endfunction

  function automatic string tag_of(input logic [31:0] x, input logic sgn,
                                   input logic [1:0] rm, input logic tr,
                                   input logic [34:0] ex);
    int e = int'(x[30:23]);
    if (tr && rm != 2'd3)               return "R11";
    if (e == 0 && x[22:0] != 0)         return "R10";
    if (e >= 159)                       return sgn ? "R6" : "R5";
    if (e < 126)                        return "R9";
    if (sgn && ex[2])                   return "R7";
    if (!sgn && x[31])                  return "R8";
    if (ex[1])                          return "R4";
    return "R3";
  endfunction

  task automatic send(input logic [31:0] v, input logic sgn,
                      input logic [1:0] rm, input logic tr);
    logic [34:0] ex;
    in_valid = 1; in_value = v; in_signed = sgn; in_rmode = rm; in_trunc = tr;
    do @(negedge clk); while (!in_ready);
    ex = model(v, sgn, rm, tr);
    q_exp.push_back(ex);
    q_in.push_back(v);
    q_tag.push_back(tag_of(v, sgn, rm, tr, ex));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // monitor / scoreboard
  logic        hold_prev = 0;
  logic [34:0] held;
  always @(negedge clk) begin
    logic [34:0] got, ex;
    logic [31:0] vin;
    string       tg;
    if (rst_n && !done) begin
      got = {out_int, out_invalid, out_inexact, out_denorm};
      if (hold_prev) begin
        n_checks++;
        if (!out_valid || got != held) begin
          n_fail++;
          $display("FAIL R2 stalled output changed: got=%h exp=%h", got, held);
        end
      end
      hold_prev = out_valid && !out_ready;
      held = got;
      if (out_valid && out_ready) begin
        n_checks++;
        if (q_exp.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected result: got=%h exp=none", got);
        end else begin
          ex = q_exp.pop_front(); vin = q_in.pop_front(); tg = q_tag.pop_front();
          if (got != ex) begin
            n_fail++;
            $display("FAIL %s in=%h got int=%h inv/inx/den=%b exp int=%h inv/inx/den=%b",
                     tg, vin, got[34:3], got[2:0], ex[34:3], ex[2:0]);
          end
        end
      end
    end
  end

  // consumer back-pressure
  initial begin
    logic [15:0] lf = 16'hACE1;
    out_ready = 1;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = (lf[2:0] != 3'd0);
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  logic [31:0] dir_vals[26] = '{
    32'h3F80_0000, 32'h4020_0000, 32'h4060_0000, 32'hC020_0000, 32'h3F00_0000,
    32'h3F40_0000, 32'hBF40_0000, 32'h3E80_0000, 32'hBE80_0000, 32'h0000_0001,
    32'h8000_0001, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'hFF80_0001,
    32'h4F00_0000, 32'hCF00_0000, 32'h4F7F_FFFF, 32'h4F80_0000, 32'hCF80_0000,
    32'hBFC0_0000, 32'h8000_0000, 32'h0000_0000, 32'h3FE0_0000, 32'h4EFF_FFFF,
    32'hCF00_0001};

  initial begin
    logic [31:0] lf = 32'h1234_5678;
    rst_n = 0; in_valid = 0; in_value = '0; in_signed = 0; in_rmode = '0; in_trunc = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 during reset: got valid=%b ready=%b exp valid=0 ready=1",
               out_valid, in_ready);
    end
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 after reset: got valid=%b ready=%b exp valid=0 ready=1",
               out_valid, in_ready);
    end
    @(posedge clk); #1;
    // directed corners: R3..R11 across every mode, both signednesses
    foreach (dir_vals[i]) begin
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 4; r++) send(dir_vals[i], s[0], r[1:0], 1'b0);
        send(dir_vals[i], s[0], 2'd0, 1'b1);   // R11 truncate override
        send(dir_vals[i], s[0], 2'd1, 1'b1);
      end
    end
    // exponent-biased pseudo-random operands
    for (int k = 0; k < 500; k++) begin
      logic [7:0] ex8;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ex8 = 8'(110 + (lf[15:8] % 55));
      send({lf[31], ex8, lf[22:0] ^ {lf[7:0], lf[30:16]}}, lf[3], lf[5:4], lf[6] & lf[2]);
    end
    wait (q_exp.size() == 0);
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule